// File: doc/BRIEF.md
# Byte-Stuffed Link Receive Decoder

This block turns the raw byte stream from a full-duplex serial link into clean payload bytes. It handles one received byte per link slot, marked by `in_valid`. Idle fill bytes are thrown away. The escape marker is removed, and the byte after it is read as a code. That code either restores a payload value which the sender had to escape, or names an in-band control event. Control events come out as single-cycle pulses on their own pins, never mixed into the payload.

A pause level follows the flow-control events. It rises on a stop request and falls on a resume request, and the local transmit encoder reads it to hold back real data. Parsing needs only two states: plain and escaped. Every registered result appears on the clock edge that accepts the byte that completes it.

Top module: `bsrx_decoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, every event pulse and `pause` are low, and the parser is in the plain state.
- R2: In the plain state, a valid byte other than 0xF0 and 0xF1 is output one cycle later with `out_valid` high and `out_byte` equal to it.
- R3: In the plain state, a valid 0xF0 is idle fill: it raises neither `out_valid` nor any event pulse, and the parser stays plain.
- R4: In the plain state, a valid 0xF1 produces no output and moves the parser to the escaped state, so that the next valid byte is read as a code.
- R5: In the escaped state, code 0x00 outputs payload byte 0xF0 and code 0x01 outputs payload byte 0xF1, each one cycle later.
- R6: In the escaped state, codes 0x02, 0x03, 0x04 and 0x05 give a one-cycle pulse on `ev_sync`, `ev_xon`, `ev_xoff` and `ev_link_err` respectively, and no payload byte.
- R7: `pause` goes high the cycle after code 0x04 is decoded and low the cycle after code 0x03 is decoded. Otherwise it holds its value.
- R8: In the escaped state, any code above 0x05, including 0xF0 and 0xF1, gives a one-cycle `ev_bad_code` pulse and no payload byte. It returns the parser to the plain state and does not start a new escape.
- R9: A cycle with `in_valid` low changes neither the parser state nor `pause`, and gives no output or pulse. An escape therefore survives gaps between slots.
- R10: At most one of `out_valid` and the five event pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A received link byte is present this cycle |
| in_byte | input | 8 | Received link byte |
| out_valid | output | 1 | Payload byte strobe |
| out_byte | output | 8 | Decoded payload byte |
| ev_sync | output | 1 | Sync control pulse |
| ev_xon | output | 1 | Resume control pulse |
| ev_xoff | output | 1 | Stop control pulse |
| ev_link_err | output | 1 | Link error control pulse |
| ev_bad_code | output | 1 | Unknown code after escape marker |
| pause | output | 1 | Transmit hold level for the local encoder |

## Verification
Every result of this block is due exactly one clock edge after the slot that carries the deciding byte. For a pair, that slot is the code byte, not the marker. This holds for the payload strobe, all five pulses and the new pause level. The bench applies each slot at a falling edge. At the next falling edge it compares the outputs with what its own model predicted for that slot, so each comparison sees only the single register stage in between. The escape state is observed through the outputs: directed pairs, gaps inside an escape, back-to-back markers and mid-escape resets show it, together with seeded random slots weighted toward the special values.

// File: rtl/bsrx_pkg.sv
package bsrx_pkg;

  localparam int BYTE_W = 8;
  localparam int NUM_EV = 5;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t FILL_BYTE = 8'hF0;
  localparam byte_t MARK_BYTE = 8'hF1;
  localparam byte_t CODE_LIT_FILL = 8'h00;
  localparam byte_t CODE_LIT_MARK = 8'h01;
  localparam byte_t CODE_SYNC = 8'h02;
  localparam byte_t CODE_XON = 8'h03;
  localparam byte_t CODE_XOFF = 8'h04;
  localparam byte_t CODE_LINKERR = 8'h05;

  // event vector positions
  localparam int EV_SYNC = 0;
  localparam int EV_XON = 1;
  localparam int EV_XOFF = 2;
  localparam int EV_LINKERR = 3;
  localparam int EV_BADCODE = 4;

  typedef enum logic [1:0] {
    ST_PLAIN = 2'd0,
    ST_ESCAPED = 2'd1
  } pstate_e;

  typedef enum logic [3:0] {
    K_NONE = 4'd0,
    K_FILL = 4'd1,
    K_MARK = 4'd2,
    K_DATA = 4'd3,
    K_SYNC = 4'd4,
    K_XON = 4'd5,
    K_XOFF = 4'd6,
    K_LINKERR = 4'd7,
    K_BADCODE = 4'd8
  } kind_e;

  // Meaning of one slot, given whether the previous byte opened an escape.
  function automatic kind_e classify(input logic vld, input logic esc, input byte_t b);
    kind_e k;
    if (!vld) begin
      k = K_NONE;
    end else if (!esc) begin
      if (b == FILL_BYTE) k = K_FILL;
      else if (b == MARK_BYTE) k = K_MARK;
      else k = K_DATA;
    end else begin
      case (b)
        CODE_LIT_FILL, CODE_LIT_MARK: k = K_DATA;
        CODE_SYNC: k = K_SYNC;
        CODE_XON: k = K_XON;
        CODE_XOFF: k = K_XOFF;
        CODE_LINKERR: k = K_LINKERR;
        default: k = K_BADCODE;
      endcase
    end
    return k;
  endfunction

  // Payload value of a data slot.
  function automatic byte_t restore(input logic esc, input byte_t b);
    byte_t r;
    if (!esc) r = b;
    else if (b == CODE_LIT_FILL) r = FILL_BYTE;
    else r = MARK_BYTE;
    return r;
  endfunction

  // One-hot event vector for a slot kind.
  function automatic logic [NUM_EV-1:0] kind_events(input kind_e k);
    logic [NUM_EV-1:0] v;
    v = '0;
    case (k)
      K_SYNC: v[EV_SYNC] = 1'b1;
      K_XON: v[EV_XON] = 1'b1;
      K_XOFF: v[EV_XOFF] = 1'b1;
      K_LINKERR: v[EV_LINKERR] = 1'b1;
      K_BADCODE: v[EV_BADCODE] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/bsrx_classify.sv
module bsrx_classify
  import bsrx_pkg::*;
(
  input logic vld,
  input logic esc,
  input byte_t raw,
  output kind_e kind,
  output byte_t payload
);

  always_comb begin
    kind = classify(vld, esc, raw);
    payload = restore(esc, raw);
  end

endmodule

// File: rtl/bsrx_escape_fsm.sv
module bsrx_escape_fsm
  import bsrx_pkg::*;
(
  input logic clk,
  input logic rst,
  input kind_e kind,
  output logic esc_active
);

  pstate_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (kind)
      K_NONE: st_d = st_q;
      K_MARK: st_d = ST_ESCAPED;
      default: st_d = ST_PLAIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_PLAIN;
    else st_q <= st_d;
  end

  assign esc_active = (st_q == ST_ESCAPED);

  // R9: no slot, no state change
  p_gap_holds_state_r9: assert property (@(posedge clk) disable iff (rst)
    (kind == K_NONE) |=> $stable(esc_active));

  // R4: marker opens escape
  p_marker_enters_escape_r4: assert property (@(posedge clk) disable iff (rst)
    (kind == K_MARK) |=> esc_active);

  // R8: a completed pair always leaves the escaped state
  p_pair_closes_escape_r8: assert property (@(posedge clk) disable iff (rst)
    (esc_active && kind != K_NONE) |=> !esc_active);

endmodule

// File: rtl/bsrx_event_gen.sv
module bsrx_event_gen
  import bsrx_pkg::*;
(
  input logic clk,
  input logic rst,
  input kind_e kind,
  input byte_t payload,
  output logic data_vld,
  output byte_t data_byte,
  output logic [NUM_EV-1:0] ev_pulse,
  output logic hold
);

  logic [NUM_EV-1:0] ev_next;
  assign ev_next = kind_events(kind);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EV; gi++) begin : g_pulse
      always_ff @(posedge clk) begin
        if (rst) ev_pulse[gi] <= 1'b0;
        else ev_pulse[gi] <= ev_next[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      data_vld <= 1'b0;
      data_byte <= '0;
    end else begin
      data_vld <= (kind == K_DATA);
      if (kind == K_DATA) data_byte <= payload;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hold <= 1'b0;
    else if (kind == K_XOFF) hold <= 1'b1;
    else if (kind == K_XON) hold <= 1'b0;
  end

  // R7: pause follows flow-control events
  p_pause_set_r7: assert property (@(posedge clk) disable iff (rst)
    (kind == K_XOFF) |=> hold);
  p_pause_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (kind == K_XON) |=> !hold);
  p_pause_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (kind != K_XON && kind != K_XOFF) |=> $stable(hold));

  // R10: mutually exclusive results
  p_one_result_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({data_vld, ev_pulse}));

endmodule

// File: rtl/bsrx_decoder.sv
module bsrx_decoder
  import bsrx_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic [7:0] in_byte,
  output logic out_valid,
  output logic [7:0] out_byte,
  output logic ev_sync,
  output logic ev_xon,
  output logic ev_xoff,
  output logic ev_link_err,
  output logic ev_bad_code,
  output logic pause
);

  logic esc_active;
  kind_e slot_kind;
  byte_t slot_payload;
  logic [NUM_EV-1:0] ev_vec;

  bsrx_classify u_classify (
    .vld(in_valid),
    .esc(esc_active),
    .raw(in_byte),
    .kind(slot_kind),
    .payload(slot_payload)
  );

  bsrx_escape_fsm u_fsm (
    .clk(clk),
    .rst(rst),
    .kind(slot_kind),
    .esc_active(esc_active)
  );

  bsrx_event_gen u_events (
    .clk(clk),
    .rst(rst),
    .kind(slot_kind),
    .payload(slot_payload),
    .data_vld(out_valid),
    .data_byte(out_byte),
    .ev_pulse(ev_vec),
    .hold(pause)
  );

  assign ev_sync = ev_vec[EV_SYNC];
  assign ev_xon = ev_vec[EV_XON];
  assign ev_xoff = ev_vec[EV_XOFF];
  assign ev_link_err = ev_vec[EV_LINKERR];
  assign ev_bad_code = ev_vec[EV_BADCODE];

  // R2: plain byte passes through
  p_plain_passes_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !esc_active && in_byte != 8'hF0 && in_byte != 8'hF1)
    |=> (out_valid && out_byte == $past(in_byte)));

  // R3: fill dropped
  p_fill_dropped_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !esc_active && in_byte == 8'hF0)
    |=> (!out_valid && ev_vec == '0 && !esc_active));

  // R4: marker silent
  p_marker_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !esc_active && in_byte == 8'hF1) |=> (!out_valid && ev_vec == '0));

  // R5: escaped literals
  p_lit_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && esc_active && in_byte == 8'h00) |=> (out_valid && out_byte == 8'hF0));
  p_lit_mark_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && esc_active && in_byte == 8'h01) |=> (out_valid && out_byte == 8'hF1));

  // R6: control codes pulse
  p_sync_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && esc_active && in_byte == 8'h02) |=> (ev_sync && !out_valid));
  p_linkerr_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && esc_active && in_byte == 8'h05) |=> (ev_link_err && !out_valid));

  // R8: unknown codes
  p_bad_code_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && esc_active && in_byte > 8'h05) |=> (ev_bad_code && !out_valid && !esc_active));

  // R9: empty slot gives nothing
  p_gap_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && ev_vec == '0 && $stable(pause)));

  // R1: first cycle after reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && ev_vec == '0 && !pause && !esc_active));

endmodule

// File: tb/bsrx_decoder_bench.sv
module bsrx_decoder_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic out_valid, ev_sync, ev_xon, ev_xoff, ev_link_err, ev_bad_code, pause;
  logic [7:0] out_byte;

  always #5 clk = ~clk;

  bsrx_decoder u_bsrx_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .ev_sync(ev_sync), .ev_xon(ev_xon),
    .ev_xoff(ev_xoff), .ev_link_err(ev_link_err), .ev_bad_code(ev_bad_code), .pause(pause)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  bit m_esc = 1'b0;
  bit m_pause = 1'b0;
  bit e_valid = 1'b0;
  logic [7:0] e_byte = 8'h00;
  logic [4:0] e_ev = 5'b0; // {bad, linkerr, xoff, xon, sync}
  string e_req = "R1";

  function automatic logic [7:0] unesc(input logic [7:0] c);
    return (c == 8'h00) ? 8'hF0 : 8'hF1;
  endfunction

  task automatic model(input bit v, input logic [7:0] b);
    e_valid = 1'b0; e_ev = 5'b0;
    if (!v) begin
      e_req = "R9";
    end else if (!m_esc) begin
      if (b == 8'hF0) e_req = "R3";
      else if (b == 8'hF1) begin e_req = "R4"; m_esc = 1'b1; end
      else begin e_req = "R2"; e_valid = 1'b1; e_byte = b; end
    end else begin
      m_esc = 1'b0;
      if (b <= 8'h01) begin e_req = "R5"; e_valid = 1'b1; e_byte = unesc(b); end
      else if (b == 8'h02) begin e_req = "R6"; e_ev[0] = 1'b1; end
      else if (b == 8'h03) begin e_req = "R7"; e_ev[1] = 1'b1; m_pause = 1'b0; end
      else if (b == 8'h04) begin e_req = "R7"; e_ev[2] = 1'b1; m_pause = 1'b1; end
      else if (b == 8'h05) begin e_req = "R6"; e_ev[3] = 1'b1; end
      else begin e_req = "R8"; e_ev[4] = 1'b1; end
    end
  endtask

  task automatic compare();
    logic [4:0] got_ev;
    got_ev = {ev_bad_code, ev_link_err, ev_xoff, ev_xon, ev_sync};
    n_tests++;
    if (out_valid !== e_valid || got_ev !== e_ev || pause !== m_pause ||
        (e_valid && out_byte !== e_byte)) begin
      n_fail++;
      $display("FAIL %s: got v=%0b b=%02h ev=%05b p=%0b exp v=%0b b=%02h ev=%05b p=%0b",
               e_req, out_valid, out_byte, got_ev, pause, e_valid, e_byte, e_ev, m_pause);
    end
    if (!$onehot0({out_valid, got_ev})) begin
      n_fail++;
      $display("FAIL R10: got v=%0b ev=%05b exp at most one high", out_valid, got_ev);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] b);
    @(negedge clk);
    compare();
    in_valid = v;
    in_byte = b;
    model(v, b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    compare();
    rst = 1'b1; in_valid = 1'b0; in_byte = 8'h00;
    m_esc = 1'b0; m_pause = 1'b0;
    e_valid = 1'b0; e_ev = 5'b0; e_req = "R1";
    @(negedge clk);
    @(negedge clk);
    compare();
    rst = 1'b0;
    e_req = "R1";
  endtask

  function automatic logic [7:0] pick_byte();
    int unsigned r;
    r = $urandom % 10;
    case (r)
      0, 1: return 8'hF0;
      2, 3: return 8'hF1;
      4, 5, 6: return 8'($urandom % 8);
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    do_reset();                       // R1
    step(1, 8'h41);                   // R2 plain data
    step(1, 8'h00);                   // R2 zero as plain data
    step(1, 8'hF0);                   // R3 fill
    step(1, 8'hF1); step(1, 8'h00);   // R4, R5 -> F0
    step(1, 8'hF1); step(1, 8'h01);   // R5 -> F1
    step(1, 8'hF1); step(1, 8'h02);   // R6 sync
    step(1, 8'hF1); step(1, 8'h05);   // R6 link error
    step(1, 8'hF1); step(1, 8'h04);   // R7 pause set
    step(1, 8'h7E);                   // R7 held
    step(1, 8'hF1); step(0, 8'h03); step(0, 8'h00); step(1, 8'h03); // R9 gap inside escape, R7 clear
    step(1, 8'hF1); step(1, 8'hF1); step(1, 8'h01); // R8 marker as code, then plain 01
    step(1, 8'hF1); step(1, 8'hF0); step(1, 8'h33); // R8 fill as code
    step(1, 8'hF1); step(1, 8'h06);   // R8 first unknown code
    step(1, 8'hF1); step(1, 8'h04);   // pause set again
    step(1, 8'hF1);                   // escape open
    do_reset();                       // R1 clears pause and escape
    step(1, 8'h04);                   // plain after reset (R1, R2)
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 5) != 0, pick_byte());
    end
    step(0, 8'h00);
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no finish, exp finish within limit");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule